// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a single-clock pipelined SRAM. It has a word bus split into byte lanes, and each lane carries eight data bits plus one parity bit. Every synchronous control is active low and is sampled on the rising clock edge:

- two address strobes (`adsp_n` and `adsc_n`);
- a burst advance (`adv_n`);
- a chip enable (`ce_n`);
- per-lane byte writes (`bw_n`) gated by a byte-write enable (`bwe_n`);
- a global write (`gw_n`).

The address, the write data and the burst-order select are also sampled on the rising edge. The output enable is not sampled: it gates the read data combinationally.

An access begins when either strobe loads a new address. Following cycles can step a 2-bit burst counter, so the block produces one new word every clock after the first. The counter steps the low two address bits in linear or interleaved order. Reads pass through an address register and an output register, so the first word arrives on the third clock, counting the clock in which the address is presented, and each later word follows one clock after the previous one. A write commits at the edge after it is sampled, so a read issued in the very next cycle already sees the new data.

The tri-state data pins are modelled as a data-out bus (`dout`) plus a valid flag (`dout_vld`). Memory contents are unknown until written.

Top module: `pbs_sram`

## Requirements
- R1: A low on `adsp_n` or `adsc_n` while `ce_n` is low loads `addr_i` and starts an access. The word read by an access sampled at edge n is on `dout` from just after edge n+1, together with `dout_vld` high.
- R2: An access loaded with `adsp_n` low is always a read. `gw_n`, `bwe_n`, `bw_n` and `din` are ignored for it, and memory is unchanged.
- R3: In a cycle with both strobes high, `adv_n` low and the device selected, the 2-bit burst counter steps by one. The stepped address is accessed that cycle, so a burst delivers one word per clock after the first.
- R4: The low two address bits of a burst access are as follows:
  - with `burst_ilv` = 0 (linear): the loaded low bits plus the count, modulo 4;
  - with `burst_ilv` = 1 (interleaved): the loaded low bits XOR the count.
  In both orders the upper address bits stay as loaded.
- R5: In a cycle with both strobes high and `adv_n` high, the device accesses the same address as in the previous cycle.
- R6: Byte-lane writes follow these rules:
  - with `gw_n` high and `bwe_n` low, lane i (`din` bits 9i+8..9i, with parity at bit 9i+8) is written when `bw_n[i]` is low, and the other lanes keep their content;
  - with `bwe_n` and `gw_n` both high, `bw_n` is ignored and the access is a read.
- R7: With `gw_n` low, every lane of the addressed word is written, whatever `bwe_n` and `bw_n` are. This does not apply to an access loaded with `adsp_n` low (see R2).
- R8: A read in the cycle right after a write to the same address returns the newly written data.
- R9: A load with `ce_n` high deselects the device. Until the next load, no access takes place: nothing is written and `dout_vld` stays low.
- R10: `dout_vld` is high only while `oe_n` is low and read data is held. `oe_n` acts without a clock edge, and `dout` is zero whenever `dout_vld` is low.
- R11: After reset, no access is pending and `dout_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| addr_i | input | AW | Word address |
| adsp_n | input | 1 | Processor address strobe, loads a read |
| adsc_n | input | 1 | Controller address strobe, loads a read or write |
| adv_n | input | 1 | Burst advance |
| ce_n | input | 1 | Chip enable, captured at load |
| gw_n | input | 1 | Global write, all lanes |
| bwe_n | input | 1 | Byte-write enable |
| bw_n | input | LANES | Per-lane byte writes |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable |
| din | input | LANES*9 | Write data with parity per lane |
| dout | output | LANES*9 | Read data, zero when not valid |
| dout_vld | output | 1 | Read data driven |

## Verification
The bench first fills a block of words with global writes. It then reads them back as four-word bursts in linear order, in interleaved order and from a start that wraps, which separates the two counter orders and shows the upper address bits are held. Held-advance cycles, strobe-loaded writes with single-lane enables, and write controls on processor-strobe loads each show whether a lane, the counter or the memory moved when it should not. A write followed at once by a read of the same word separates a committed write from a lagging one. A deselected burst with writes asserted, and an output enable toggled between clock edges, cover the cases where nothing may be driven or stored.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    localparam int LANE_W = 9;

    // low two address bits of a burst beat
    function automatic logic [1:0] burst_offset(input logic [1:0] base,
                                                input logic [1:0] cnt,
                                                input logic       ilv);
        return ilv ? (base ^ cnt) : (base + cnt);
    endfunction

endpackage

// File: rtl/pbs_burst_addr.sv
module pbs_burst_addr #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          adv_i,
    input  logic          ilv_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] acc_addr_o
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [1:0]    cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (load_i) begin
            ctr_d.base = addr_i;
            ctr_d.cnt  = 2'd0;
        end else if (adv_i) begin
            ctr_d.cnt  = ctr_q.cnt + 2'd1;
        end
        acc_addr_o = {ctr_d.base[AW-1:2],
                      pbs_pkg::burst_offset(ctr_d.base[1:0], ctr_d.cnt, ilv_i)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    // R3: a load restarts the count, an advance steps it by one
    assert_burst_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ctr_q.cnt == 2'd0);
    assert_burst_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_i) |=> ctr_q.cnt == $past(ctr_q.cnt) + 2'd1);
    // R5: no load and no advance keeps the burst state
    assert_burst_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(ctr_q));

endmodule

// File: rtl/pbs_lane_store.sv
module pbs_lane_store #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      we_i,
    input  logic                      re_i,
    input  logic [AW-1:0]             addr_i,
    input  logic [pbs_pkg::LANE_W-1:0] wdata_i,
    output logic [pbs_pkg::LANE_W-1:0] rdata_o
);
    logic [pbs_pkg::LANE_W-1:0] mem [DEPTH];
    logic [pbs_pkg::LANE_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) mem[addr_i] <= wdata_i;
        if (re_i) rdata_q     <= mem[addr_i];
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/pbs_sram.sv
module pbs_sram #(
    parameter int DEPTH = 64,
    parameter int LANES = 2,
    localparam int AW   = $clog2(DEPTH),
    localparam int DW   = LANES * pbs_pkg::LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_i,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic             ce_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             burst_ilv,
    input  logic             oe_n,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    output logic             dout_vld
);
    typedef struct packed {
        logic             sel;
        logic             acc;
        logic [LANES-1:0] lane_we;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
        logic             rd_vld;
    } pipe_t;

    pipe_t         pipe_d, pipe_q;
    logic          load_c, adv_c;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] rd_word;
    logic          rd_act;

    pbs_burst_addr #(.AW(AW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_c),
        .adv_i      (adv_c),
        .ilv_i      (burst_ilv),
        .addr_i     (addr_i),
        .acc_addr_o (acc_addr)
    );

    always_comb begin
        load_c = !adsp_n || !adsc_n;
        adv_c  = !load_c && !adv_n && pipe_q.sel;
        pipe_d = pipe_q;
        pipe_d.sel  = load_c ? !ce_n : pipe_q.sel;
        pipe_d.acc  = pipe_d.sel;
        pipe_d.addr = acc_addr;
        pipe_d.data = din;
        if (!pipe_d.sel || (load_c && !adsp_n)) pipe_d.lane_we = '0;
        else if (!gw_n)                         pipe_d.lane_we = '1;
        else if (!bwe_n)                        pipe_d.lane_we = ~bw_n;
        else                                    pipe_d.lane_we = '0;
        pipe_d.rd_vld = pipe_q.acc && (pipe_q.lane_we == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign rd_act = pipe_q.acc && (pipe_q.lane_we == '0);

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        pbs_lane_store #(.DEPTH(DEPTH)) u_lane (
            .clk     (clk),
            .we_i    (pipe_q.acc && pipe_q.lane_we[gi]),
            .re_i    (rd_act),
            .addr_i  (pipe_q.addr),
            .wdata_i (pipe_q.data[gi*pbs_pkg::LANE_W +: pbs_pkg::LANE_W]),
            .rdata_o (rd_word[gi*pbs_pkg::LANE_W +: pbs_pkg::LANE_W])
        );
    end

    assign dout_vld = pipe_q.rd_vld && !oe_n;
    assign dout     = dout_vld ? rd_word : '0;

    // R2: processor-strobe loads never write
    assert_adsp_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adsp_n |=> pipe_q.lane_we == '0);
    // R7: global write on a controller load covers every lane
    assert_global_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n && !adsc_n && !ce_n && !gw_n) |=> &pipe_q.lane_we);
    // R6: byte writes follow the inverted lane inputs
    assert_byte_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n && !adsc_n && !ce_n && gw_n && !bwe_n) |=> pipe_q.lane_we == ~$past(bw_n));
    // R9: a deselecting load leaves no access
    assert_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load_c && ce_n) |=> !pipe_q.acc);
    // R1: held read data always comes from a read access one edge earlier
    assert_read_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.rd_vld |-> $past(pipe_q.acc && pipe_q.lane_we == '0));
    // R10: a high output enable leaves the bus quiet
    always_comb begin
        if (rst_n && oe_n) assert_oe_quiet_R10: assert (!dout_vld && dout == '0);
    end

endmodule

// File: tb/pbs_sram_test.sv
module pbs_sram_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int LANES = 2;
    localparam int AW = 6;
    localparam int LW = 9;
    localparam int DW = LANES * LW;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [AW-1:0]    addr_i;
    logic             adsp_n, adsc_n, adv_n, ce_n, gw_n, bwe_n, burst_ilv, oe_n;
    logic [LANES-1:0] bw_n;
    logic [DW-1:0]    din, dout;
    logic             dout_vld;

    pbs_sram #(.DEPTH(DEPTH), .LANES(LANES)) uut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce_n(ce_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .burst_ilv(burst_ilv), .oe_n(oe_n), .din(din), .dout(dout), .dout_vld(dout_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R11";

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // behavioural reference model
    logic [DW-1:0] mm [DEPTH];
    bit            m_sel, pend_v, exp_rv;
    int            m_base, m_cnt, pend_addr, pend_mask, low;
    logic [DW-1:0] pend_data, exp_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; pend_v = 0; exp_rv = 0; m_cnt = 0; m_base = 0;
        end else begin
            bit ld;
            exp_rv = 0;
            if (pend_v) begin
                if (pend_mask != 0) begin
                    for (int l = 0; l < LANES; l++)
                        if (pend_mask[l]) mm[pend_addr][l*LW +: LW] = pend_data[l*LW +: LW];
                end else begin
                    exp_rv = 1;
                    exp_data = mm[pend_addr];
                end
            end
            ld = !adsp_n || !adsc_n;
            if (ld) begin
                m_sel = !ce_n; m_base = int'(addr_i); m_cnt = 0;
            end else if (m_sel && !adv_n) begin
                m_cnt = (m_cnt + 1) % 4;
            end
            low = burst_ilv ? ((m_base % 4) ^ m_cnt) : ((m_base % 4 + m_cnt) % 4);
            pend_addr = (m_base / 4) * 4 + low;
            pend_v = m_sel;
            if (ld && !adsp_n)  pend_mask = 0;
            else if (!gw_n)     pend_mask = (1 << LANES) - 1;
            else if (!bwe_n)    pend_mask = int'(~bw_n);
            else                pend_mask = 0;
            pend_data = din;
        end
    end

    // compare on every clock, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n) begin
            bit ev;
            ev = exp_rv && !oe_n;
            check(dout_vld === ev, cur_req, "dout_vld", DW'(dout_vld), DW'(ev));
            if (ev) check(dout === exp_data, cur_req, "dout", dout, exp_data);
            else    check(dout === '0, cur_req, "dout idle", dout, '0);
        end
    end

    function automatic logic [DW-1:0] fval(input int a);
        return DW'((a * 7919 + 333) & ((1 << DW) - 1));
    endfunction

    task automatic cyc(input bit sp, input bit sc, input bit av, input bit ce,
                       input bit gw, input bit be, input logic [LANES-1:0] bw,
                       input int a, input logic [DW-1:0] d);
        @(negedge clk);
        adsp_n = sp; adsc_n = sc; adv_n = av; ce_n = ce;
        gw_n = gw; bwe_n = be; bw_n = bw; addr_i = AW'(a); din = d;
    endtask

    task automatic idle();
        cyc(1, 0, 1, 1, 1, 1, '1, 0, '0);
    endtask

    task automatic rd_burst(input int a, input bit ilv);
        @(negedge clk) burst_ilv = ilv;
        cyc(0, 1, 1, 0, 1, 1, '1, a, '0);
        for (int k = 0; k < 3; k++) cyc(1, 1, 0, 0, 1, 1, '1, 0, '0);
        idle(); idle();
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        rst_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1; ce_n = 1; gw_n = 1; bwe_n = 1;
        bw_n = '1; burst_ilv = 0; oe_n = 0; addr_i = '0; din = '0;
        repeat (3) @(negedge clk);
        check(dout_vld === 1'b0, "R11", "dout_vld in reset", DW'(dout_vld), '0);
        check(dout === '0, "R11", "dout in reset", dout, '0);
        rst_n = 1;
        idle();
        @(posedge clk) #(CLK_PERIOD/4 + 1);
        check(dout_vld === 1'b0, "R11", "dout_vld after reset", DW'(dout_vld), '0);

        cur_req = "R7";
        for (int a = 0; a < 16; a++) cyc(1, 0, 1, 0, 0, 1, 2'b11, a, fval(a));
        idle(); idle();

        cur_req = "R1 R3 R4 linear";
        rd_burst(4, 0);
        cur_req = "R4 interleaved";
        rd_burst(6, 1);
        cur_req = "R4 wrap";
        rd_burst(7, 0);
        rd_burst(13, 1);

        cur_req = "R5";
        burst_ilv = 0;
        cyc(0, 1, 1, 0, 1, 1, '1, 9, '0);
        cyc(1, 1, 1, 0, 1, 1, '1, 0, '0);
        cyc(1, 1, 0, 0, 1, 1, '1, 0, '0);
        cyc(1, 1, 1, 0, 1, 1, '1, 0, '0);
        idle(); idle();

        cur_req = "R2";
        cyc(0, 1, 1, 0, 0, 0, 2'b00, 3, '1);
        idle();
        cyc(0, 1, 1, 0, 1, 1, '1, 3, '0);
        idle(); idle();

        cur_req = "R6";
        cyc(1, 0, 1, 0, 1, 0, 2'b10, 3, 18'h2a5c3);
        cyc(1, 0, 1, 0, 1, 1, '1, 3, '0);
        cyc(1, 0, 1, 0, 1, 0, 2'b01, 5, 18'h15a3c);
        cyc(1, 0, 1, 0, 1, 1, '1, 5, '0);
        cyc(1, 0, 1, 0, 1, 1, 2'b00, 3, '1);
        cyc(1, 0, 1, 0, 1, 1, '1, 3, '0);
        idle(); idle();

        cur_req = "R8";
        cyc(1, 0, 1, 0, 0, 1, '1, 10, 18'h3c0f1);
        cyc(1, 0, 1, 0, 1, 1, '1, 10, '0);
        cyc(1, 0, 1, 0, 0, 1, '1, 12, 18'h00101);
        cyc(1, 1, 0, 0, 0, 1, '1, 0, 18'h00202);
        cyc(1, 1, 0, 0, 0, 1, '1, 0, 18'h00303);
        cyc(1, 1, 0, 0, 0, 1, '1, 0, 18'h00404);
        idle();
        rd_burst(12, 0);

        cur_req = "R9";
        cyc(1, 0, 0, 1, 0, 1, '1, 2, 18'h0dead);
        cyc(1, 1, 0, 0, 0, 1, '1, 0, 18'h0beef);
        cyc(1, 1, 0, 0, 0, 1, '1, 0, 18'h0cafe);
        cyc(1, 1, 1, 0, 1, 1, '1, 0, '0);
        rd_burst(0, 0);

        cur_req = "R10";
        cyc(0, 1, 1, 0, 1, 1, '1, 11, '0);
        idle();
        @(posedge clk) #(CLK_PERIOD/4 + 1);
        oe_n = 1; #1;
        check(dout_vld === 1'b0, "R10", "dout_vld with oe high", DW'(dout_vld), '0);
        check(dout === '0, "R10", "dout with oe high", dout, '0);
        oe_n = 0; #1;
        check(dout_vld === 1'b1, "R10", "dout_vld with oe low", DW'(dout_vld), 1);
        check(dout === fval(11), "R10", "dout with oe low", dout, fval(11));
        idle(); idle();
        @(posedge clk) #(CLK_PERIOD/2);
        report();
    end

endmodule